// File: doc/BRIEF.md
# SPI Slave Boot Receive Port

This block is the slave end of a four-wire SPI link that carries a boot image of 32-bit words. A host clocks words in on MOSI while the slave's select line is held low. Each complete word lands in a two-entry receive buffer, and a local consumer drains that buffer through a ready/valid read port. The SPI clock, select and MOSI are oversampled on the system clock through two-flop synchronisers, so the SPI clock must run well below the system clock.

On MISO the port returns 32-bit words. The local side writes a transmit word through a one-cycle strobe. At every word slot the port sends that word if it is new. If no new word has been written, a mode input chooses what goes out instead: either the last written word again, or all zeros. A host can use this behaviour as a handshake while the local side is busy.

If the local side stalls and a third word completes while both buffer entries are full, the port drops that word and raises a sticky overflow flag. Only taking the port out of enable clears the flag.

Top module: `spi_boot_slave`

## Requirements
- R1: Words are received in SPI mode 0 with the MSB first. MOSI is sampled on each rising SCLK edge while select is low, and every 32 rising edges form one word. Words appear on the read port in arrival order, and several words may be sent inside one select frame.
- R2: The receive buffer holds up to two words. `rd_valid` is high while the buffer is not empty, `rd_data` shows the oldest word, and a cycle with `rd_valid` and `rd_ready` both high removes that word.
- R3: `overflow` goes to 1 when a word completes while two words are held and no word is read in that cycle. Reading words does not clear it. It returns to 0 only after `en` has been low.
- R4: When an overflow occurs, the incoming word is discarded and the two held words are kept unchanged and in order.
- R5: MISO sends its word MSB first. The first bit is valid before the first rising SCLK edge of the slot, and each later bit follows a falling edge. A word written with `tx_wr` is sent in full in the next word slot that starts after the write.
- R6: With `zero_idle` = 0, a word slot that starts without a new write sends the last written word again. After reset that word is 0.
- R7: With `zero_idle` = 1, a word slot that starts without a new write sends 32 zero bits.
- R8: Raising select in the middle of a word discards the bits received so far. The next word starts again at bit 31.
- R9: While `en` is 0 the buffer is emptied, `overflow` is cleared and all SPI activity is ignored, so no word is stored. MISO is 0 whenever the port is disabled or not selected.
- R10: After reset `rd_valid` is 0, `overflow` is 0 and `miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low clears the buffer and the overflow flag |
| zero_idle | input | 1 | Idle transmit policy: 1 sends zeros, 0 repeats the last word |
| sclk | input | 1 | SPI clock from the host |
| cs_n | input | 1 | Slave select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| tx_wr | input | 1 | One-cycle strobe that writes `tx_data` as the next transmit word |
| tx_data | input | 32 | Transmit word |
| rd_data | output | 32 | Oldest received word |
| rd_valid | output | 1 | Receive buffer not empty |
| rd_ready | input | 1 | Consumer accepts `rd_data` |
| overflow | output | 1 | Sticky receive overflow flag |

## Verification
The bench fills the buffer with three words in one select frame and does not drain it. A design that overwrote an entry or accepted the third word would return the wrong pair of words or show a third valid word. The bench also checks that the overflow flag survives reads, which a flag cleared by reads would fail. A select frame cut after ten bits and followed by a full word exposes a bit counter that keeps its count across frames, because the received word would come out shifted. Transmit slots with and without a fresh write, in both idle modes, catch a port that sends stale data in zero mode or zeros in repeat mode. A frame sent while disabled catches a port that still stores words when `en` is low.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
    localparam int WORD_W      = 32;
    localparam int BUF_DEPTH   = 2;
    localparam int SYNC_STAGES = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        IDLE_REPEAT = 1'b0,
        IDLE_ZERO   = 1'b1
    } idle_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic active;
        logic start;
        logic mosi;
    } pin_ev_t;

    function automatic word_t idle_word(input idle_mode_e mode, input word_t last);
        return (mode == IDLE_ZERO) ? '0 : last;
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_boot_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk,
    input  logic    cs_n,
    input  logic    mosi,
    output pin_ev_t ev
);
    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] mosi_q;
    logic              sclk_d;
    logic              act_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
            sclk_d <= 1'b0;
            act_d  <= 1'b0;
        end else begin
            sclk_q <= {sclk_q[STAGES-2:0], sclk};
            cs_q   <= {cs_q[STAGES-2:0], cs_n};
            mosi_q <= {mosi_q[STAGES-2:0], mosi};
            sclk_d <= sclk_q[STAGES-1];
            act_d  <= ~cs_q[STAGES-1];
        end
    end

    always_comb begin
        ev.rise   = sclk_q[STAGES-1] & ~sclk_d;
        ev.fall   = ~sclk_q[STAGES-1] & sclk_d;
        ev.active = ~cs_q[STAGES-1];
        ev.start  = ~cs_q[STAGES-1] & ~act_d;
        ev.mosi   = mosi_q[STAGES-1];
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_boot_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  pin_ev_t      ev,
    input  logic [W-1:0] load_word,
    output logic         load_take,
    output logic         word_done,
    output logic [W-1:0] rx_word,
    output logic         miso_bit
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     rx_sh;
    logic [W-1:0]     tx_sh;

    assign active = en & ev.active;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= '0;
        end else begin
            if (ev.start) begin
                tx_sh <= load_word;
            end else if (ev.fall) begin
                if (cnt == '0) tx_sh <= load_word;
                else           tx_sh <= {tx_sh[W-2:0], 1'b0};
            end
            if (ev.rise) begin
                rx_sh <= {rx_sh[W-2:0], ev.mosi};
                cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
        end
    end

    assign load_take = active & (ev.start | (ev.fall & (cnt == '0)));
    assign word_done = active & ev.rise & (cnt == LAST);
    assign rx_word   = {rx_sh[W-2:0], ev.mosi};
    assign miso_bit  = active & tx_sh[W-1];

    // R1: the synchroniser never reports both SCLK edges at once
    assert_edge_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(ev.rise && ev.fall));

    // R8: an inactive select leaves the bit counter at word start
    assert_partial_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt == '0) || ev.rise);
endmodule

// File: rtl/spi_tx_stage.sv
module spi_tx_stage
    import spi_boot_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tx_wr,
    input  logic [W-1:0] tx_data,
    input  logic         take,
    input  idle_mode_e   mode,
    output logic [W-1:0] load_word
);
    logic [W-1:0] hold;
    logic         fresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= '0;
            fresh <= 1'b0;
        end else if (tx_wr) begin
            hold  <= tx_data;
            fresh <= 1'b1;
        end else if (take) begin
            fresh <= 1'b0;
        end
    end

    assign load_word = fresh ? hold : idle_word(mode, hold);

    // R5: a written word stays pending until a slot takes it
    assert_pending_R5: assert property (@(posedge clk) disable iff (rst)
        (fresh && !take && !tx_wr) |=> fresh && $stable(hold));
endmodule

// File: rtl/spi_rx_buf.sv
module spi_rx_buf
    import spi_boot_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int DEPTH = BUF_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             do_pop;
    logic             do_push;

    assign full    = (count == CNT_FULL);
    assign do_pop  = pop & (count != '0);
    assign do_push = push & (!full | do_pop);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push && full && !do_pop) ovf <= 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            always_ff @(posedge clk) begin
                if (do_push && wr_ptr == PTR_W'(i)) mem[i] <= push_data;
            end
        end
    endgenerate

    assign head      = mem[rd_ptr];
    assign not_empty = (count != '0);

    assert_depth_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_FULL);

    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (ovf && en) |=> ovf);

    assert_drop_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (en && push && full && !pop) |=> ovf && full && (head == $past(head)));
endmodule

// File: rtl/spi_boot_slave.sv
module spi_boot_slave
    import spi_boot_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        zero_idle,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    output logic        miso,
    input  logic        tx_wr,
    input  logic [31:0] tx_data,
    output logic [31:0] rd_data,
    output logic        rd_valid,
    input  logic        rd_ready,
    output logic        overflow
);
    pin_ev_t ev;
    word_t   load_word;
    word_t   rx_word;
    logic    load_take;
    logic    word_done;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .cs_n (cs_n),
        .mosi (mosi),
        .ev   (ev)
    );

    spi_shift_core #(.W(WORD_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .ev        (ev),
        .load_word (load_word),
        .load_take (load_take),
        .word_done (word_done),
        .rx_word   (rx_word),
        .miso_bit  (miso)
    );

    spi_tx_stage #(.W(WORD_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tx_wr     (tx_wr),
        .tx_data   (tx_data),
        .take      (load_take),
        .mode      (idle_mode_e'(zero_idle)),
        .load_word (load_word)
    );

    spi_rx_buf #(.W(WORD_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .push      (word_done),
        .push_data (rx_word),
        .pop       (rd_ready),
        .head      (rd_data),
        .not_empty (rd_valid),
        .ovf       (overflow)
    );

    // R9: disabling empties the buffer and clears the flag one cycle later
    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !rd_valid && !overflow);

    // R9: MISO is quiet whenever the port is disabled
    assert_quiet_miso_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!en) && !en |-> !miso);
endmodule

// File: tb/spi_boot_slave_bench.sv
module spi_boot_slave_bench;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        zero_idle = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        tx_wr = 1'b0;
    logic [31:0] tx_data = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic        overflow;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    spi_boot_slave u_spi_boot_slave (
        .clk(clk), .rst(rst), .en(en), .zero_idle(zero_idle),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .tx_wr(tx_wr), .tx_data(tx_data), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .overflow(overflow)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] tx;
        logic        zmode;
        logic [31:0] din;
        logic [31:0] exp_miso;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 32'hA5A5_0F0F, 1'b0, 32'hDEAD_BEEF, 32'hA5A5_0F0F},
        '{1'b0, 32'h0000_0000, 1'b0, 32'h1234_5678, 32'hA5A5_0F0F},
        '{1'b0, 32'h0000_0000, 1'b1, 32'h8000_0001, 32'h0000_0000},
        '{1'b1, 32'hC3C3_3C3C, 1'b1, 32'hFFFF_FFFF, 32'hC3C3_3C3C},
        '{1'b0, 32'h0000_0000, 1'b1, 32'h0000_0000, 32'h0000_0000},
        '{1'b0, 32'h0000_0000, 1'b0, 32'h5A5A_5A5A, 32'hC3C3_3C3C}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_tx(input logic [31:0] d);
        @(negedge clk);
        tx_data = d;
        tx_wr   = 1'b1;
        @(negedge clk);
        tx_wr   = 1'b0;
    endtask

    task automatic shift_bits(input logic [31:0] d, input int nbits, output logic [31:0] got);
        got = '0;
        for (int i = 31; i > 31 - nbits; i--) begin
            mosi = d[i];
            wait_clk(HALF);
            got[i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic select_low();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic select_high();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic pop_word(output logic [31:0] d);
        d = '0;
        for (int k = 0; k < 20 && !rd_valid; k++) @(negedge clk);
        d = rd_data;
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic [31:0] m0;
        logic [31:0] m1;
        logic [31:0] m2;

        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R10: reset state
        check("R10 rd_valid", {31'b0, rd_valid}, 32'd0);
        check("R10 overflow", {31'b0, overflow}, 32'd0);
        check("R10 miso",     {31'b0, miso},     32'd0);
        en = 1'b1;
        wait_clk(2);

        // R1 R2 R5 R6 R7: one word per frame, table-driven
        for (int v = 0; v < 6; v++) begin
            if (VECS[v].wr) write_tx(VECS[v].tx);
            zero_idle = VECS[v].zmode;
            select_low();
            shift_bits(VECS[v].din, 32, m0);
            select_high();
            check($sformatf("R5/R6/R7 miso vec%0d", v), m0, VECS[v].exp_miso);
            pop_word(got);
            check($sformatf("R1/R2 rx vec%0d", v), got, VECS[v].din);
        end

        // R3 R4 R5 R7: three words in one frame, no draining
        zero_idle = 1'b1;
        write_tx(32'h0F1E_2D3C);
        select_low();
        shift_bits(32'h1111_0001, 32, m0);
        shift_bits(32'h2222_0002, 32, m1);
        shift_bits(32'h3333_0003, 32, m2);
        select_high();
        check("R5 fresh word first slot", m0, 32'h0F1E_2D3C);
        check("R7 zero second slot",      m1, 32'h0);
        check("R7 zero third slot",       m2, 32'h0);
        check("R3 overflow set", {31'b0, overflow}, 32'd1);
        pop_word(got);
        check("R4 first kept",  got, 32'h1111_0001);
        pop_word(got);
        check("R4 second kept", got, 32'h2222_0002);
        wait_clk(2);
        check("R4 third dropped", {31'b0, rd_valid}, 32'd0);
        check("R3 overflow survives reads", {31'b0, overflow}, 32'd1);
        en = 1'b0;
        wait_clk(2);
        en = 1'b1;
        wait_clk(2);
        check("R3 overflow cleared by disable", {31'b0, overflow}, 32'd0);

        // R6: repeat mode resends last word across slots in one frame
        zero_idle = 1'b0;
        select_low();
        shift_bits(32'hAAAA_5555, 32, m0);
        shift_bits(32'h5555_AAAA, 32, m1);
        select_high();
        check("R6 repeat slot a", m0, 32'h0F1E_2D3C);
        check("R6 repeat slot b", m1, 32'h0F1E_2D3C);
        pop_word(got);
        check("R1 multi-word a", got, 32'hAAAA_5555);
        pop_word(got);
        check("R1 multi-word b", got, 32'h5555_AAAA);

        // R8: partial word discarded
        select_low();
        shift_bits(32'hFFFF_FFFF, 10, m0);
        select_high();
        select_low();
        shift_bits(32'h0123_4567, 32, m0);
        select_high();
        pop_word(got);
        check("R8 word after partial", got, 32'h0123_4567);
        wait_clk(2);
        check("R8 no extra word", {31'b0, rd_valid}, 32'd0);

        // R9: bus ignored while disabled
        en = 1'b0;
        wait_clk(2);
        select_low();
        shift_bits(32'hCAFE_F00D, 32, m0);
        select_high();
        check("R9 miso low while disabled", m0, 32'h0);
        en = 1'b1;
        wait_clk(4);
        check("R9 nothing stored", {31'b0, rd_valid}, 32'd0);
        check("R9 miso low unselected", {31'b0, miso}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule